// File: doc/BRIEF.md
# Processor Run/Halt Controller

This block starts and halts a configurable group of processor threads, here called VPs, and keeps a running mask for them. Software reaches it over a small register bus. A run-request register starts selected VPs. A stop-request register halts selected VPs. A status register returns the running mask. The three registers appear in two address windows: a cluster window and a local window. Accesses through either window have the same effect.

Starting a VP does not mark it running straight away. The controller sends that VP a one-cycle reset pulse and holds it in a pending state. The VP becomes running only when it returns its reset-done acknowledge. A stop acts only on VPs that are already running, and clears their running state at once. Each VP has a halt level output that is high whenever the VP is not running.

After the controller leaves reset, all VPs are halted. It then issues one start for the VPs chosen by a boot parameter.

Top module: `vp_run_ctrl`

## Requirements
- R1: Only the low NUM_VP bits of run and stop data take effect. Higher data bits are ignored, and status bits 63 down to NUM_VP always read as zero.
- R2: A write to the run register (offset 0x10 in a window) pulses `vp_rst_pulse[i]` in the cycle after the write, for every VP i whose data bit is 1 and which is neither running nor pending.
- R3: Each reset pulse lasts exactly one cycle. A run request gives no pulse to a VP that is already running or already pending.
- R4: A pending VP becomes running in the cycle after its `vp_rst_done` is sampled high. `vp_rst_done` on a VP that is not pending has no effect. `vp_halt[i]` is 1 exactly when VP i is not running.
- R5: A write to the stop register (offset 0x18) makes every running VP whose data bit is 1 halted in the cycle after the write. A stop has no effect on a halted or pending VP, and a pending start still completes.
- R6: A read of the status register (offset 0x30) returns the running mask, zero-extended, on `bus_rdata` in the cycle after the read. `bus_rdata` holds its value when no read is made.
- R7: The registers are decoded at CL_BASE (default 0x000) plus the offset and at CO_BASE (default 0x100) plus the offset. Both windows behave identically.
- R8: A write to any other address changes nothing. A read of any other address returns zero.
- R9: While reset is active, all VPs are halted, no pulse is driven and `bus_rdata` is zero. In the third cycle after reset release (two synchroniser stages plus one register), a single start is issued for the VPs selected by START_RUNNING.
- R10: A START_RUNNING value with a bit at or above NUM_VP is reported as an error at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 64 | Write data (VP bitmask) |
| bus_rdata | output | 64 | Read data, registered one cycle after the read |
| vp_rst_pulse | output | NUM_VP | One-cycle reset pulse for each VP that is being started |
| vp_halt | output | NUM_VP | High while the VP is not running |
| vp_rst_done | input | NUM_VP | Reset-complete acknowledge from each VP |

## Verification
Reset pulses, halt changes and read data each appear one register stage after the bus access or acknowledge that causes them. The bench therefore drives every stimulus at a falling edge and compares the outputs at the following falling edge, after exactly one rising edge has passed. The boot start comes through a two-stage reset synchroniser and then a register, so the bench counts three rising edges after reset release before it expects the boot pulse. It also checks that the outputs are quiet on the two edges before that. Pending-versus-running behaviour is tested with acknowledges and stops in the same cycle, and with run requests repeated while a start is still pending.

// File: rtl/vpctl_pkg.sv
package vpctl_pkg;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_RUN    = 2'd1,
    ACC_STOP   = 2'd2,
    ACC_STATUS = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/vpctl_rst_sync.sv
module vpctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/vpctl_decode.sv
module vpctl_decode
  import vpctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CL_BASE    = 'h000,
  parameter logic [ADDR_W-1:0] CO_BASE    = 'h100,
  parameter logic [ADDR_W-1:0] RUN_OFS    = 'h10,
  parameter logic [ADDR_W-1:0] STOP_OFS   = 'h18,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h30
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind
);

  localparam int unsigned NWIN = 2;
  localparam logic [ADDR_W-1:0] BASES [NWIN] = '{CL_BASE, CO_BASE};

  logic [NWIN-1:0] hit_run, hit_stop, hit_stat;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit_run[w]  = (addr == BASES[w] + RUN_OFS);
    assign hit_stop[w] = (addr == BASES[w] + STOP_OFS);
    assign hit_stat[w] = (addr == BASES[w] + STATUS_OFS);
  end

  always_comb begin
    kind = ACC_NONE;
    if (|hit_run)       kind = ACC_RUN;
    else if (|hit_stop) kind = ACC_STOP;
    else if (|hit_stat) kind = ACC_STATUS;
  end

endmodule

// File: rtl/vpctl_slot.sv
module vpctl_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  input  logic rst_done,
  output logic running,
  output logic rst_pulse
);

  logic running_q, running_d;
  logic pending_q, pending_d;
  logic pulse_q,   pulse_d;
  logic start_take;

  always_comb begin
    start_take = start_req & ~running_q & ~pending_q;
    running_d  = running_q;
    pending_d  = pending_q;
    pulse_d    = start_take;
    if (start_take) pending_d = 1'b1;
    if (pending_q && rst_done) begin
      running_d = 1'b1;
      pending_d = 1'b0;
    end
    if (stop_req && running_q) running_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      pending_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      running_q <= running_d;
      pending_q <= pending_d;
      pulse_q   <= pulse_d;
    end
  end

  assign running   = running_q;
  assign rst_pulse = pulse_q;

endmodule

// File: rtl/vpctl_rdata.sv
module vpctl_rdata #(
  parameter int unsigned NUM_VP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic [NUM_VP-1:0] status,
  output logic [63:0]       rdata
);

  logic [63:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rd_hit ? 64'(status) : 64'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 64'd0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
  import vpctl_pkg::*;
#(
  parameter int unsigned NUM_VP        = 1,
  parameter logic [63:0] START_RUNNING = 64'h1,
  parameter int unsigned ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] CL_BASE    = 'h000,
  parameter logic [ADDR_W-1:0] CO_BASE    = 'h100,
  parameter logic [ADDR_W-1:0] RUN_OFS    = 'h10,
  parameter logic [ADDR_W-1:0] STOP_OFS   = 'h18,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic [NUM_VP-1:0] vp_rst_pulse,
  output logic [NUM_VP-1:0] vp_halt,
  input  logic [NUM_VP-1:0] vp_rst_done
);

  localparam logic [NUM_VP-1:0] BOOT_SET = START_RUNNING[NUM_VP-1:0];

  logic        rst_n_int;
  acc_kind_e   kind;
  logic        wr_run, wr_stop, rd_en, rd_hit;
  logic        boot_q, boot_d;
  logic [NUM_VP-1:0] start_vec, stop_vec, running;
  logic        unused_wdata;

  vpctl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  vpctl_decode #(
    .ADDR_W     (ADDR_W),
    .CL_BASE    (CL_BASE),
    .CO_BASE    (CO_BASE),
    .RUN_OFS    (RUN_OFS),
    .STOP_OFS   (STOP_OFS),
    .STATUS_OFS (STATUS_OFS)
  ) u_decode (
    .addr (bus_addr),
    .kind (kind)
  );

  assign wr_run  = bus_valid &  bus_write & (kind == ACC_RUN);
  assign wr_stop = bus_valid &  bus_write & (kind == ACC_STOP);
  assign rd_en   = bus_valid & ~bus_write;
  assign rd_hit  = (kind == ACC_STATUS);
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    boot_d    = 1'b0;
    start_vec = (wr_run ? bus_wdata[NUM_VP-1:0] : '0)
              | (boot_q ? BOOT_SET : '0);
    stop_vec  = wr_stop ? bus_wdata[NUM_VP-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      boot_q <= 1'b1;
    end else begin
      boot_q <= boot_d;
    end
  end

  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    vpctl_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .start_req (start_vec[i]),
      .stop_req  (stop_vec[i]),
      .rst_done  (vp_rst_done[i]),
      .running   (running[i]),
      .rst_pulse (vp_rst_pulse[i])
    );
  end

  assign vp_halt = ~running;

  vpctl_rdata #(
    .NUM_VP (NUM_VP)
  ) u_rdata (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .rd_en  (rd_en),
    .rd_hit (rd_hit),
    .status (running),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/vp_run_ctrl_chk.sv
module vp_run_ctrl_chk #(
  parameter int unsigned NUM_VP        = 1,
  parameter logic [63:0] START_RUNNING = 64'h1,
  parameter int unsigned ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] CL_BASE    = 'h000,
  parameter logic [ADDR_W-1:0] CO_BASE    = 'h100,
  parameter logic [ADDR_W-1:0] STOP_OFS   = 'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [63:0]       bus_wdata,
  input logic [63:0]       bus_rdata,
  input logic [NUM_VP-1:0] vp_rst_pulse,
  input logic [NUM_VP-1:0] vp_halt,
  input logic [NUM_VP-1:0] vp_rst_done
);

  localparam logic [63:0] VMASK = (NUM_VP >= 64) ? {64{1'b1}} : ((64'd1 << NUM_VP) - 64'd1);

  initial begin
    p_boot_mask_r10: assert ((START_RUNNING & ~VMASK) == 64'd0)
      else $error("START_RUNNING has bits outside NUM_VP");
  end

  logic stop_wr;
  assign stop_wr = bus_valid && bus_write &&
                   (bus_addr == CL_BASE + STOP_OFS || bus_addr == CO_BASE + STOP_OFS);

  p_rdata_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~VMASK) == 64'd0);

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_rst_pulse & $past(vp_rst_pulse)) == '0);

  p_pulse_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_rst_pulse & ~vp_halt) == '0);

  p_run_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~vp_halt & $past(vp_halt)) & ~$past(vp_rst_done)) == '0);

  p_stop_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> ((~vp_halt & $past(bus_wdata[NUM_VP-1:0]) & ~$past(vp_rst_done)) == '0));

  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind vp_run_ctrl vp_run_ctrl_chk #(
  .NUM_VP        (NUM_VP),
  .START_RUNNING (START_RUNNING),
  .ADDR_W        (ADDR_W),
  .CL_BASE       (CL_BASE),
  .CO_BASE       (CO_BASE),
  .STOP_OFS      (STOP_OFS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .vp_rst_pulse (vp_rst_pulse),
  .vp_halt      (vp_halt),
  .vp_rst_done  (vp_rst_done)
);

// File: tb/vp_run_ctrl_bench.sv
`timescale 1ns/100ps
module vp_run_ctrl_bench;

  localparam int unsigned NVP = 8;
  localparam logic [63:0] BOOT = 64'h05;

  logic        clk;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic [NVP-1:0] vp_rst_pulse, vp_halt, vp_rst_done;

  int n_cmp;
  int n_bad;
  bit done_flag;

  vp_run_ctrl #(
    .NUM_VP        (NVP),
    .START_RUNNING (BOOT)
  ) u_vp_run_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .vp_rst_pulse (vp_rst_pulse),
    .vp_halt      (vp_halt),
    .vp_rst_done  (vp_rst_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // kind: 0 idle, 1 write, 2 read
  typedef struct packed {
    logic [1:0]  kind;
    logic [11:0] addr;
    logic [63:0] data;
    logic [7:0]  done;
    logic [7:0]  pulse;
    logic [7:0]  halt;
    logic [63:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R4: boot VPs 0 and 2 acknowledge
    '{2'd0, 12'h000, 64'h0,                   8'h05, 8'h00, 8'hFA, 64'h0,  8'd4},
    // R6: status read, cluster window
    '{2'd2, 12'h030, 64'h0,                   8'h00, 8'h00, 8'hFA, 64'h05, 8'd6},
    // R2 R1 R7: run via local window, high bits ignored, VP0 already running
    '{2'd1, 12'h110, 64'hFFFF_FF00_0000_0013, 8'h00, 8'h12, 8'hFA, 64'h05, 8'd2},
    // R5: stop of pending VPs has no effect
    '{2'd1, 12'h018, 64'h12,                  8'h00, 8'h00, 8'hFA, 64'h05, 8'd5},
    // R4: VP1 acknowledges
    '{2'd0, 12'h000, 64'h0,                   8'h02, 8'h00, 8'hF8, 64'h05, 8'd4},
    // R3: run on a pending VP gives no second pulse
    '{2'd1, 12'h010, 64'h10,                  8'h00, 8'h00, 8'hF8, 64'h05, 8'd3},
    // R5: pending VP4 still completes
    '{2'd0, 12'h000, 64'h0,                   8'h10, 8'h00, 8'hE8, 64'h05, 8'd5},
    // R4: acknowledge on a non-pending VP is ignored
    '{2'd0, 12'h000, 64'h0,                   8'h21, 8'h00, 8'hE8, 64'h05, 8'd4},
    // R5 R1 R7: stop via local window, bit 8 out of range
    '{2'd1, 12'h118, 64'h0000_0000_0000_0101, 8'h00, 8'h00, 8'hE9, 64'h05, 8'd5},
    // R7: status via local window
    '{2'd2, 12'h130, 64'h0,                   8'h00, 8'h00, 8'hE9, 64'h16, 8'd7},
    // R8: write to unmapped offset
    '{2'd1, 12'h020, 64'hFF,                  8'h00, 8'h00, 8'hE9, 64'h16, 8'd8},
    // R8: read of unmapped offset
    '{2'd2, 12'h038, 64'h0,                   8'h00, 8'h00, 8'hE9, 64'h0,  8'd8},
    // R5: stop of a halted VP
    '{2'd1, 12'h018, 64'h40,                  8'h00, 8'h00, 8'hE9, 64'h0,  8'd5},
    // R6: status read
    '{2'd2, 12'h030, 64'h0,                   8'h00, 8'h00, 8'hE9, 64'h16, 8'd6},
    // R2: restart VP0
    '{2'd1, 12'h010, 64'h01,                  8'h00, 8'h01, 8'hE9, 64'h16, 8'd2},
    // R5 R4: stop VP1 while VP0 acknowledges
    '{2'd1, 12'h018, 64'h02,                  8'h01, 8'h00, 8'hEA, 64'h16, 8'd5},
    // R6: final status
    '{2'd2, 12'h130, 64'h0,                   8'h00, 8'h00, 8'hEA, 64'h15, 8'd6}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_idle();
    bus_valid   = 1'b0;
    bus_write   = 1'b0;
    bus_addr    = '0;
    bus_wdata   = '0;
    vp_rst_done = '0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 50000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done_flag = 1'b0;
    bus_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "pulse in reset", 64'(vp_rst_pulse), 64'h0);
    check("R9", "halt in reset",  64'(vp_halt),      64'hFF);
    check("R9", "rdata in reset", bus_rdata,         64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "pulse edge1", 64'(vp_rst_pulse), 64'h0);
    @(negedge clk);
    check("R9", "pulse edge2", 64'(vp_rst_pulse), 64'h0);
    @(negedge clk);
    check("R9", "boot pulse",  64'(vp_rst_pulse), 64'h05);
    check("R9", "boot halt",   64'(vp_halt),      64'hFF);

    for (int k = 0; k < NV; k++) begin
      bus_valid   = (VECS[k].kind != 2'd0);
      bus_write   = (VECS[k].kind == 2'd1);
      bus_addr    = VECS[k].addr;
      bus_wdata   = VECS[k].data;
      vp_rst_done = VECS[k].done;
      @(negedge clk);
      bus_idle();
      check($sformatf("R%0d", VECS[k].req), $sformatf("vec%0d pulse", k),
            64'(vp_rst_pulse), 64'(VECS[k].pulse));
      check($sformatf("R%0d", VECS[k].req), $sformatf("vec%0d halt", k),
            64'(vp_halt), 64'(VECS[k].halt));
      check($sformatf("R%0d", VECS[k].req), $sformatf("vec%0d rdata", k),
            bus_rdata, VECS[k].rdata);
    end

    // R3: pulse over after one cycle
    @(negedge clk);
    check("R3", "pulse cleared", 64'(vp_rst_pulse), 64'h0);

    // R9: reset mid-run forces all halted
    rst_n = 1'b0;
    #1;
    check("R9", "halt on async reset", 64'(vp_halt), 64'hFF);
    @(negedge clk);
    check("R9", "rdata cleared", bus_rdata, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", "no early pulse", 64'(vp_rst_pulse), 64'h0);
    @(negedge clk);
    check("R9", "reboot pulse", 64'(vp_rst_pulse), 64'h05);
    @(negedge clk);
    check("R9", "reboot pulse single", 64'(vp_rst_pulse), 64'h0);
    vp_rst_done = 8'h04;
    @(negedge clk);
    vp_rst_done = '0;
    check("R4", "VP2 running", 64'(vp_halt), 64'hFB);

    // R1: run data with only high bits set starts nothing
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h010;
    bus_wdata = 64'hFFFF_FFFF_FFFF_FF00;
    @(negedge clk);
    bus_idle();
    check("R1", "high bits ignored", 64'(vp_rst_pulse), 64'h0);
    check("R1", "halt unchanged", 64'(vp_halt), 64'hFB);

    // R6: read data holds with no access
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h030;
    @(negedge clk);
    bus_idle();
    check("R6", "status after reboot", bus_rdata, 64'h04);
    repeat (2) @(negedge clk);
    check("R6", "rdata held", bus_rdata, 64'h04);

    finish_run();
  end

endmodule